// File: doc/BRIEF.md
# Receive Buffer Status Responder

This block handles the receive side of a token-passing network node that stores incoming frames in a paged buffer RAM. It keeps one status flag, the receiver-inhibited flag (`ri`). The flag tells the host that the current page holds a finished frame. It also tells remote senders whether this node can accept another frame. When a remote node sends a free-buffer enquiry, the block answers one cycle later. It acknowledges when the flag is clear and refuses when the flag is set.

When the receive path signals the end of a frame, the flag is set. The interrupt line follows the flag, gated by a host mask bit. With the mask clear, the host polls `ri` instead. The host re-arms reception with an enable command that carries a page number. That command clears the flag and selects the page that the next frame lands in. A separate configuration strobe chooses between small pages and pages twice that size. The block turns the selected page number into the base byte address of the page inside the buffer.

Top module: `rx_page_responder`

## Requirements
- R1: After reset, `ri` is 1, `resp_valid` is 0 and `page_base` is 0 (page 0, small pages).
- R2: A cycle with `rx_done` high and `arm_valid` low makes `ri` read 1 from the next cycle on.
- R3: A cycle with `arm_valid` high makes `ri` read 0 from the next cycle on. The same command stores `arm_page` as the selected page.
- R4: When `arm_valid` and `rx_done` are high in the same cycle, the command wins, and `ri` reads 0 in the next cycle.
- R5: `resp_valid` is high for exactly the one cycle that follows each cycle in which `enq_valid` is high, and is low otherwise.
- R6: `resp_ack` in a response cycle is 1 (acknowledge) when `ri` was 0 in the enquiry cycle, and 0 (refuse) when it was 1.
- R7: With small pages (`cfg_big` stored as 0), `page_base` equals the selected page times `SMALL_PAGE` (256 bytes by default).
- R8: With large pages (`cfg_big` stored as 1 by `cfg_wr`), `page_base` equals (selected page modulo half the small-page count) times 2*`SMALL_PAGE`. A change of page size takes effect in the cycle after `cfg_wr`, and the stored page number is kept.
- R9: `irq` equals `ri` AND `irq_mask` at all times.
- R10: Without an enable command, `ri` never returns from 1 to 0 and the selected page does not change. In particular, `rx_done` while `ri` is already 1 changes neither.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_valid | input | 1 | Enable-receive command strobe |
| arm_page | input | PAGE_W (3) | Page number that comes with the command |
| cfg_wr | input | 1 | Page-size configuration strobe |
| cfg_big | input | 1 | Page size written on `cfg_wr`: 0 small, 1 double |
| irq_mask | input | 1 | Interrupt enable for the `ri` flag |
| enq_valid | input | 1 | A free-buffer enquiry was received |
| rx_done | input | 1 | End-of-reception pulse |
| resp_valid | output | 1 | Request to send an answer to the enquiry |
| resp_ack | output | 1 | Answer kind: 1 acknowledge, 0 refuse |
| page_base | output | ADDR_W (11) | Byte base address of the selected page |
| ri | output | 1 | Receiver-inhibited flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench goes after the cycle where re-arming and end-of-reception collide. A design that gave the end-of-reception priority there would leave the node refusing frames until the host re-armed it again. It sends enquiries in the very cycle the flag changes. This catches a design that answers from the updated flag instead of the flag as it stood, which would acknowledge into a full page. It switches page size while an odd upper page number is selected, which exposes wrong modulo folding or a page register cleared by configuration. It also toggles the mask while the flag is set, to catch an interrupt that is edge-latched rather than level-gated.

// File: rtl/rx_page_responder.sv
module rx_page_responder #(
  parameter int BUF_BYTES  = 2048,
  parameter int SMALL_PAGE = 256,
  localparam int ADDR_W    = $clog2(BUF_BYTES),
  localparam int SMALL_SH  = $clog2(SMALL_PAGE),
  localparam int PAGE_W    = ADDR_W - SMALL_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_valid,
  input  logic [PAGE_W-1:0] arm_page,
  input  logic              cfg_wr,
  input  logic              cfg_big,
  input  logic              irq_mask,
  input  logic              enq_valid,
  input  logic              rx_done,
  output logic              resp_valid,
  output logic              resp_ack,
  output logic [ADDR_W-1:0] page_base,
  output logic              ri,
  output logic              irq
);

  logic [PAGE_W-1:0] page_q;
  logic              big_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ri     <= 1'b1;
      page_q <= '0;
    end else if (arm_valid) begin
      ri     <= 1'b0;
      page_q <= arm_page;
    end else if (rx_done) begin
      ri     <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      big_q <= 1'b0;
    else if (cfg_wr) big_q <= cfg_big;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
    end else begin
      resp_valid <= enq_valid;
      if (enq_valid) resp_ack <= ~ri;
    end
  end

  logic [ADDR_W-1:0] base_small, base_big;
  assign base_small = ADDR_W'(page_q) << SMALL_SH;
  assign base_big   = ADDR_W'(page_q[PAGE_W-2:0]) << (SMALL_SH + 1);
  assign page_base  = big_q ? base_big : base_small;
  assign irq        = ri & irq_mask;

  // R2
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !arm_valid |=> ri);

  // R3
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_valid |=> !ri && page_q == $past(arm_page));

  // R5
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid |=> resp_valid);

  // R5
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enq_valid |=> !resp_valid);

  // R6
  resp_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid |=> resp_ack == !$past(ri));

  // R10
  ri_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ri && !arm_valid |=> ri);

  // R10
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_valid |=> $stable(page_q));

endmodule

// File: tb/rx_page_responder_bench.sv
module rx_page_responder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_valid = 0, cfg_wr = 0, cfg_big = 0, irq_mask = 0, enq_valid = 0, rx_done = 0;
  logic [2:0] arm_page = '0;
  logic resp_valid, resp_ack, ri, irq;
  logic [10:0] page_base;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_ri = 1, m_page = 0, m_big = 0, m_rv = 0, m_ack = 0;

  always #4 clk = ~clk;

  rx_page_responder u_rx_page_responder (
    .clk(clk), .rst_n(rst_n), .arm_valid(arm_valid), .arm_page(arm_page),
    .cfg_wr(cfg_wr), .cfg_big(cfg_big), .irq_mask(irq_mask),
    .enq_valid(enq_valid), .rx_done(rx_done), .resp_valid(resp_valid),
    .resp_ack(resp_ack), .page_base(page_base), .ri(ri), .irq(irq));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ri = 1; m_page = 0; m_big = 0; m_rv = 0; m_ack = 0;
    end else begin
      m_rv = enq_valid;
      if (enq_valid) m_ack = (m_ri == 0);
      if (cfg_wr) m_big = cfg_big;
      if (arm_valid) begin m_ri = 0; m_page = arm_page; end
      else if (rx_done) m_ri = 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_base();
    return m_big ? (m_page % 4) * 512 : m_page * 256;
  endfunction

  task automatic compare_all();
    chk("R2 R3 R4 R10 ri", ri, m_ri);
    chk("R5 resp_valid", resp_valid, m_rv);
    if (m_rv) chk("R6 resp_ack", resp_ack, m_ack);
    chk("R7 R8 page_base", page_base, exp_base());
    chk("R9 irq", irq, m_ri & irq_mask);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    arm_valid = 0; cfg_wr = 0; enq_valid = 0; rx_done = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #20;
    chk("R1 ri reset", ri, 1);
    chk("R1 resp_valid reset", resp_valid, 0);
    chk("R1 page_base reset", page_base, 0);
    @(negedge clk); rst_n = 1;
    step();
    // R6 enquiry while full gets refused
    enq_valid = 1; step();
    chk("R6 nak when full", resp_ack, 0);
    step();
    chk("R5 single cycle", resp_valid, 0);
    // R3 arm page 5, R7 base
    arm_valid = 1; arm_page = 3'd5; step();
    chk("R3 ri cleared", ri, 0);
    chk("R7 small base", page_base, 1280);
    // R6 ack, with rx_done same cycle (answer uses old flag)
    enq_valid = 1; rx_done = 1; step();
    chk("R6 ack from pre-edge flag", resp_ack, 1);
    chk("R2 ri set", ri, 1);
    // R9 mask toggling
    irq_mask = 1; step();
    chk("R9 irq on", irq, 1);
    irq_mask = 0; step();
    chk("R9 irq off", irq, 0);
    // R10 rx_done while full
    rx_done = 1; step();
    chk("R10 ri stays", ri, 1);
    chk("R10 page kept", page_base, 1280);
    // R4 collision
    arm_valid = 1; arm_page = 3'd7; rx_done = 1; step();
    chk("R4 arm wins", ri, 0);
    // R8 big pages, page 7 -> 3*512
    cfg_wr = 1; cfg_big = 1; step();
    chk("R8 big base", page_base, 1536);
    cfg_wr = 1; cfg_big = 0; step();
    chk("R8 back to small keeps page", page_base, 1792);
    irq_mask = 1;
    for (int i = 0; i < 400; i++) begin
      arm_valid = ($urandom % 6) == 0;
      arm_page  = 3'($urandom);
      rx_done   = ($urandom % 4) == 0;
      enq_valid = ($urandom % 3) == 0;
      cfg_wr    = ($urandom % 10) == 0;
      cfg_big   = 1'($urandom);
      irq_mask  = 1'($urandom);
      @(posedge clk);
      @(negedge clk);
      compare_all();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule